// File: doc/BRIEF.md
# Indirect Register Access Mailbox Bridge

This block is the target side of a two-register indirect access port. A host on a simple 32-bit memory-mapped bus sees a transfer register and a status register. Through them it reaches a remote register space addressed with 24 bits. The host writes a command word to the transfer register. For writes it then writes one data word. It polls the status register until the ready bit is set. It then reads the response words back out of the transfer register, one word per read.

Toward the remote space the block drives a request/acknowledge port. The request carries the address, a write flag, a system-space flag and the write data. It is held steady until the remote side acknowledges, and the acknowledge may flag an error. Interrupt-clear, status-query and null commands are completed locally. Unknown opcodes are answered with an error code. Writes to the transfer register that arrive while a transaction is in flight are dropped and recorded.

A host that finds the ready bit already set can drain a stale response. It reads the transfer register until the ready bit drops, and each read consumes one pending word.

Top module: `mbx_bridge`

## Requirements
- R1: A command word holds the opcode in bits 31:24 and the remote address in bits 23:0. The address appears unchanged on `rm_addr` for the remote request.
- R2: Opcode 0x01 (read) and 0x02 (system read) raise `rm_valid` in the cycle after the command write, with `rm_write`=0. `rm_sys` is 1 only for 0x02. Once acknowledged, the response is two words: first the status word, then the data returned on `rm_rdata`.
- R3: `hb_sel`=1 selects the status register and `hb_sel`=0 selects the transfer register. Bit 0 of the status register is the ready flag and bits 31:1 read as zero. Writes to the status register are ignored.
- R4: Opcode 0x10 (write) and 0x20 (system write) start no request until the data word has been written to the transfer register. That word then appears on `rm_wdata` with `rm_write`=1, and `rm_sys` is 1 only for 0x20. The response is a single status word.
- R5: The request stays asserted, with its address and write flag unchanged, until `rm_ack`. Ready is set in the cycle after the acknowledge, and ready is never set while a request is pending.
- R6: The status word has bits 7:0 as a result code: 0x00 for success, 0x01 when `rm_err` accompanied the acknowledge, 0x02 for an unsupported opcode. An unsupported opcode completes without a remote request and returns data 0.
- R7: A transfer-register write while a request is pending or a response is ready is ignored. It sets bit 8 of the status word, and that bit stays set until the next command is accepted.
- R8: Opcodes 0x00 (null), 0x40 (interrupt clear) and 0x80 (status query) complete without a remote request. Ready is set in the cycle after the command, the status word is 0 and the data word is 0.
- R9: Reset, including reset in the middle of a transaction, clears ready, drops any request and returns the block to waiting for a command.
- R10: Ready falls only after the last response word is read. Each transfer-register read while ready consumes one word. Transfer-register reads while not ready return 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_wr | input | 1 | Host write strobe, one cycle per access |
| hb_rd | input | 1 | Host read strobe, one cycle per access |
| hb_sel | input | 1 | Register select: 0 transfer, 1 status |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid in the cycle of the read strobe |
| rm_valid | output | 1 | Remote request pending |
| rm_write | output | 1 | Remote request is a write |
| rm_sys | output | 1 | Remote request targets system space |
| rm_addr | output | 24 | Remote register address |
| rm_wdata | output | 32 | Remote write data |
| rm_ack | input | 1 | Remote acknowledge, one-cycle pulse |
| rm_rdata | input | 32 | Remote read data, valid with the acknowledge |
| rm_err | input | 1 | Remote error flag, valid with the acknowledge |

## Verification
The assertions assume that `rm_ack` is pulsed only while `rm_valid` is high. They also assume the host never raises `hb_wr` and `hb_rd` together, so that a completion or drain is never mixed with a write. The bench's remote responder waits until it sees the request before it answers. Every host access is a single-cycle strobe of exactly one kind, driven on the falling edge. The bench still issues deliberate out-of-phase transfer writes and idle reads, because those are behaviours the block is required to handle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OP_NULL  = 8'h00;
  localparam logic [7:0] OP_RD    = 8'h01;
  localparam logic [7:0] OP_SYSRD = 8'h02;
  localparam logic [7:0] OP_WR    = 8'h10;
  localparam logic [7:0] OP_SYSWR = 8'h20;
  localparam logic [7:0] OP_ICLR  = 8'h40;
  localparam logic [7:0] OP_QRY   = 8'h80;

  localparam logic [7:0] RC_OK     = 8'h00;
  localparam logic [7:0] RC_REMOTE = 8'h01;
  localparam logic [7:0] RC_BADOP  = 8'h02;

  typedef enum logic [2:0] {ST_IDLE, ST_DATA, ST_REQ, ST_STAT, ST_RDAT} state_t;
  typedef enum logic [1:0] {K_RMT_RD, K_RMT_WR, K_LOCAL, K_BAD} kind_t;

  typedef struct packed {
    kind_t kind;
    logic  sys;
  } cmd_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic [7:0] opc,
  output cmd_t       cmd
);
  always_comb begin
    cmd.sys = 1'b0;
    unique case (opc)
      OP_RD:                    cmd.kind = K_RMT_RD;
      OP_SYSRD: begin           cmd.kind = K_RMT_RD; cmd.sys = 1'b1; end
      OP_WR:                    cmd.kind = K_RMT_WR;
      OP_SYSWR: begin           cmd.kind = K_RMT_WR; cmd.sys = 1'b1; end
      OP_NULL, OP_ICLR, OP_QRY: cmd.kind = K_LOCAL;
      default:                  cmd.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_wr,
  input  logic              xfer_rd,
  input  logic [DATA_W-1:0] wdata,
  input  cmd_t              cmd,
  input  logic              rm_ack,
  input  logic [DATA_W-1:0] rm_rdata,
  input  logic              rm_err,
  output state_t            state,
  output logic              rq_write,
  output logic              rq_sys,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [DATA_W-1:0] rq_wdata,
  output logic [DATA_W-1:0] resp_stat,
  output logic [DATA_W-1:0] resp_data
);
  state_t              state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdat_q, rdat_q, rdat_d;
  logic [CODE_W-1:0]   code_q, code_d;
  logic                ovr_q, ovr_d, wr_q, wr_d, sys_q, sys_d;
  logic                cmd_en, wdat_en, rdat_en, code_en;

  // next-state and enables
  always_comb begin
    state_d = state_q;
    cmd_en  = 1'b0;
    wdat_en = 1'b0;
    rdat_en = 1'b0;
    rdat_d  = rm_rdata;
    code_en = 1'b0;
    code_d  = CODE_W'(RC_OK);
    ovr_d   = ovr_q;
    wr_d    = 1'b0;
    sys_d   = cmd.sys;
    unique case (state_q)
      ST_IDLE: if (xfer_wr) begin
        cmd_en  = 1'b1;
        code_en = 1'b1;
        rdat_en = 1'b1;
        rdat_d  = '0;
        ovr_d   = 1'b0;
        unique case (cmd.kind)
          K_RMT_RD: state_d = ST_REQ;
          K_RMT_WR: begin wr_d = 1'b1; state_d = ST_DATA; end
          K_LOCAL:  state_d = ST_STAT;
          default: begin code_d = CODE_W'(RC_BADOP); state_d = ST_STAT; end
        endcase
      end
      ST_DATA: if (xfer_wr) begin
        wdat_en = 1'b1;
        state_d = ST_REQ;
      end
      ST_REQ: begin
        if (xfer_wr) ovr_d = 1'b1;
        if (rm_ack) begin
          code_en = 1'b1;
          code_d  = rm_err ? CODE_W'(RC_REMOTE) : CODE_W'(RC_OK);
          rdat_en = !wr_q;
          state_d = ST_STAT;
        end
      end
      ST_STAT: begin
        if (xfer_wr) ovr_d = 1'b1;
        if (xfer_rd) state_d = wr_q ? ST_IDLE : ST_RDAT;
      end
      ST_RDAT: begin
        if (xfer_wr) ovr_d = 1'b1;
        if (xfer_rd) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      code_q  <= '0;
      ovr_q   <= 1'b0;
      wr_q    <= 1'b0;
      sys_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovr_q   <= ovr_d;
      if (cmd_en) begin
        addr_q <= wdata[ADDR_W-1:0];
        wr_q   <= wr_d;
        sys_q  <= sys_d;
      end
      if (wdat_en) wdat_q <= wdata;
      if (rdat_en) rdat_q <= rdat_d;
      if (code_en) code_q <= code_d;
    end
  end

  always_comb begin
    resp_stat             = '0;
    resp_stat[CODE_W-1:0] = code_q;
    resp_stat[CODE_W]     = ovr_q;
  end

  assign state     = state_q;
  assign rq_write  = wr_q;
  assign rq_sys    = sys_q;
  assign rq_addr   = addr_q;
  assign rq_wdata  = wdat_q;
  assign resp_data = rdat_q;
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 24,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_wr,
  input  logic              hb_rd,
  input  logic              hb_sel,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  output logic              rm_valid,
  output logic              rm_write,
  output logic              rm_sys,
  output logic [ADDR_W-1:0] rm_addr,
  output logic [DATA_W-1:0] rm_wdata,
  input  logic              rm_ack,
  input  logic [DATA_W-1:0] rm_rdata,
  input  logic              rm_err
);
  localparam int OPC_W = DATA_W - ADDR_W;

  logic              srst_n, xfer_wr, xfer_rd, ready, idle;
  cmd_t              cmd;
  state_t            state;
  logic [DATA_W-1:0] resp_stat, resp_data;

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mbx_decode i_decode (
    .opc(hb_wdata[DATA_W-1 -: OPC_W]), .cmd(cmd)
  );

  assign xfer_wr = hb_wr && !hb_sel;
  assign xfer_rd = hb_rd && !hb_sel;

  mbx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_ctrl (
    .clk(clk), .rst_n(srst_n), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd),
    .wdata(hb_wdata), .cmd(cmd), .rm_ack(rm_ack), .rm_rdata(rm_rdata),
    .rm_err(rm_err), .state(state), .rq_write(rm_write), .rq_sys(rm_sys),
    .rq_addr(rm_addr), .rq_wdata(rm_wdata), .resp_stat(resp_stat),
    .resp_data(resp_data)
  );

  assign ready    = (state == ST_STAT) || (state == ST_RDAT);
  assign idle     = (state == ST_IDLE);
  assign rm_valid = (state == ST_REQ);

  always_comb begin
    hb_rdata = '0;
    if (hb_sel)                hb_rdata[0] = ready;
    else if (state == ST_STAT) hb_rdata    = resp_stat;
    else if (state == ST_RDAT) hb_rdata    = resp_data;
  end
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hb_wr,
  input logic              hb_rd,
  input logic              hb_sel,
  input logic [DATA_W-1:0] hb_wdata,
  input logic [DATA_W-1:0] hb_rdata,
  input logic              rm_valid,
  input logic              rm_write,
  input logic [ADDR_W-1:0] rm_addr,
  input logic              rm_ack,
  input logic              ready,
  input logic              idle
);
  logic [7:0] opc;
  logic       cmd_wr;
  assign opc    = hb_wdata[DATA_W-1 -: 8];
  assign cmd_wr = idle && hb_wr && !hb_sel;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rm_valid && !rm_ack |=> rm_valid && $stable(rm_addr) && $stable(rm_write)); // R5
  AST_NO_READY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !rm_valid); // R5
  AST_ACK_GIVES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rm_valid && rm_ack |=> ready); // R5
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hb_sel |-> hb_rdata[DATA_W-1:1] == '0); // R3
  AST_WRITE_WAITS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (opc == 8'h10 || opc == 8'h20) |=> !rm_valid && !ready); // R4
  AST_LOCAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (opc == 8'h00 || opc == 8'h40 || opc == 8'h80) |=> ready && !rm_valid); // R8
  AST_READY_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(hb_rd && !hb_sel)); // R10
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && !hb_sel |-> hb_rdata == '0); // R10
endmodule

bind mbx_bridge mbx_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_sel(hb_sel),
  .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .rm_valid(rm_valid),
  .rm_write(rm_write), .rm_addr(rm_addr), .rm_ack(rm_ack), .ready(ready),
  .idle(idle)
);

// File: tb/test_mbx_bridge.sv
`timescale 1ns/1ps
module test_mbx_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hb_wr, hb_rd, hb_sel;
  logic [31:0] hb_wdata, hb_rdata;
  logic        rm_valid, rm_write, rm_sys;
  logic [23:0] rm_addr;
  logic [31:0] rm_wdata;
  logic        rm_ack, rm_err;
  logic [31:0] rm_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  mbx_bridge i_mbx_bridge (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_sel(hb_sel),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .rm_valid(rm_valid),
    .rm_write(rm_write), .rm_sys(rm_sys), .rm_addr(rm_addr),
    .rm_wdata(rm_wdata), .rm_ack(rm_ack), .rm_rdata(rm_rdata), .rm_err(rm_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [31:0] d);
    hb_sel = sel; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, output logic [31:0] d);
    hb_sel = sel; hb_rd = 1'b1;
    #1 d = hb_rdata;
    @(negedge clk);
    hb_rd = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    logic [31:0] s;
    int n = 0;
    s = '0;
    while (n < 40) begin
      bus_rd(1'b1, s);
      if (s[0]) break;
      n++;
    end
    check(s == 32'h1, req, s, 32'h1);
  endtask

  task automatic serve(input logic [23:0] a, input logic wr, input logic sys,
                       input logic [31:0] wd, input logic [31:0] rd,
                       input logic err, input int dly, input string req);
    int n = 0;
    while (!rm_valid && n < 40) begin @(negedge clk); n++; end
    check(rm_valid && rm_addr == a, req, {8'h0, rm_addr}, {8'h0, a});
    check(rm_write == wr && rm_sys == sys, req, {30'h0, rm_write, rm_sys}, {30'h0, wr, sys});
    if (wr) check(rm_wdata == wd, req, rm_wdata, wd);
    repeat (dly) @(negedge clk);
    rm_ack = 1'b1; rm_rdata = rd; rm_err = err;
    @(negedge clk);
    rm_ack = 1'b0; rm_rdata = '0; rm_err = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R9: reset state
  task automatic t_reset();
    logic [31:0] d;
    bus_rd(1'b1, d); check(d == 0, "R9 ready after reset", d, 0);
    check(!rm_valid, "R9 no request after reset", {31'h0, rm_valid}, 0);
    bus_rd(1'b0, d); check(d == 0, "R10 idle xfer read", d, 0);
  endtask

  // R1 R2: read and system read
  task automatic t_read(input logic [7:0] op, input logic [23:0] a, input logic [31:0] v);
    logic [31:0] d;
    bus_wr(1'b0, {op, a});
    #1 check(rm_valid, "R2 request next cycle", {31'h0, rm_valid}, 1);
    serve(a, 1'b0, op == 8'h02, 0, v, 1'b0, 2, "R1 R2 read request");
    wait_ready("R2 ready after read");
    bus_rd(1'b0, d); check(d == 0, "R2 status word", d, 0);
    bus_rd(1'b1, d); check(d == 1, "R10 ready held after first word", d, 1);
    bus_rd(1'b0, d); check(d == v, "R2 data word", d, v);
    bus_rd(1'b1, d); check(d == 0, "R10 ready falls after last word", d, 0);
  endtask

  // R4: write and system write
  task automatic t_write(input logic [7:0] op, input logic [23:0] a, input logic [31:0] v);
    logic [31:0] d;
    bus_wr(1'b0, {op, a});
    repeat (2) @(negedge clk);
    check(!rm_valid, "R4 no request before data", {31'h0, rm_valid}, 0);
    bus_wr(1'b0, v);
    serve(a, 1'b1, op == 8'h20, v, 32'hDEAD_BEEF, 1'b0, 1, "R4 write request");
    wait_ready("R4 ready after write");
    bus_rd(1'b0, d); check(d == 0, "R4 status word", d, 0);
    bus_rd(1'b1, d); check(d == 0, "R4 single word then not ready", d, 0);
  endtask

  // R6: remote error
  task automatic t_remote_err();
    logic [31:0] d;
    bus_wr(1'b0, {8'h01, 24'h00_0ABC});
    serve(24'h00_0ABC, 1'b0, 1'b0, 0, 32'h1234_5678, 1'b1, 0, "R6 err request");
    wait_ready("R6 ready after error");
    bus_rd(1'b0, d); check(d == 32'h1, "R6 remote error code", d, 32'h1);
    bus_rd(1'b0, d);
  endtask

  // R6: unsupported opcode
  task automatic t_bad_op();
    logic [31:0] d;
    bus_wr(1'b0, {8'h33, 24'h12_3456});
    #1 check(!rm_valid, "R6 bad opcode no request", {31'h0, rm_valid}, 0);
    wait_ready("R6 bad opcode ready");
    bus_rd(1'b0, d); check(d == 32'h2, "R6 bad opcode code", d, 32'h2);
    bus_rd(1'b0, d); check(d == 0, "R6 bad opcode data", d, 0);
  endtask

  // R8: locally completed opcodes
  task automatic t_local(input logic [7:0] op);
    logic [31:0] d;
    bus_wr(1'b0, {op, 24'hFF_FFFF});
    #1 check(!rm_valid, "R8 no request", {31'h0, rm_valid}, 0);
    bus_rd(1'b1, d); check(d == 1, "R8 ready next cycle", d, 1);
    bus_rd(1'b0, d); check(d == 0, "R8 status zero", d, 0);
    bus_rd(1'b0, d); check(d == 0, "R8 data zero", d, 0);
    bus_rd(1'b1, d); check(d == 0, "R8 done", d, 0);
  endtask

  // R7: overrun
  task automatic t_overrun();
    logic [31:0] d;
    bus_wr(1'b0, {8'h01, 24'h00_0100});
    bus_wr(1'b0, {8'h01, 24'h00_0999});
    check(rm_valid && rm_addr == 24'h00_0100, "R7 write during request ignored",
          {8'h0, rm_addr}, 32'h100);
    serve(24'h00_0100, 1'b0, 1'b0, 0, 32'hCAFE_0001, 1'b0, 1, "R7 request");
    wait_ready("R7 ready");
    bus_wr(1'b0, 32'h1000_0000);
    bus_rd(1'b0, d); check(d == 32'h100, "R7 overrun bit in status", d, 32'h100);
    bus_rd(1'b0, d); check(d == 32'hCAFE_0001, "R7 data unaffected by write", d, 32'hCAFE_0001);
    bus_rd(1'b1, d); check(d == 0, "R7 ignored write started nothing", d, 0);
    bus_wr(1'b0, 32'h0);
    bus_rd(1'b0, d); check(d == 0, "R7 overrun cleared by next command", d, 0);
    bus_rd(1'b0, d);
  endtask

  // R10: drain of stale responses
  task automatic t_drain();
    logic [31:0] d, s;
    int words;
    bus_wr(1'b0, {8'h02, 24'h00_0042});
    serve(24'h00_0042, 1'b0, 1'b1, 0, 32'h5A5A_A5A5, 1'b0, 3, "R10 drain request");
    wait_ready("R10 stale ready");
    words = 0;
    bus_rd(1'b1, s);
    while (s[0] && words < 8) begin
      bus_rd(1'b0, d);
      words++;
      if (words == 2) check(d == 32'h5A5A_A5A5, "R10 drained data word", d, 32'h5A5A_A5A5);
      bus_rd(1'b1, s);
    end
    check(words == 2, "R10 two words drained", words, 2);
    bus_wr(1'b0, {8'h20, 24'h00_0007});
    bus_wr(1'b0, 32'h0BAD_F00D);
    serve(24'h00_0007, 1'b1, 1'b1, 32'h0BAD_F00D, 0, 1'b0, 1, "R4 system write");
    wait_ready("R10 write stale ready");
    words = 0;
    bus_rd(1'b1, s);
    while (s[0] && words < 8) begin bus_rd(1'b0, d); words++; bus_rd(1'b1, s); end
    check(words == 1, "R10 one word drained", words, 1);
  endtask

  // R3: status register writes ignored
  task automatic t_status_wr();
    logic [31:0] d;
    bus_wr(1'b1, {8'h01, 24'h00_0001});
    repeat (2) @(negedge clk);
    check(!rm_valid, "R3 status write ignored", {31'h0, rm_valid}, 0);
    bus_rd(1'b1, d); check(d == 0, "R3 status still idle", d, 0);
  endtask

  // R9: reset mid transaction
  task automatic t_reset_mid();
    logic [31:0] d;
    bus_wr(1'b0, {8'h01, 24'h00_0055});
    #1 check(rm_valid, "R9 request before reset", {31'h0, rm_valid}, 1);
    do_reset();
    check(!rm_valid, "R9 request dropped", {31'h0, rm_valid}, 0);
    bus_rd(1'b1, d); check(d == 0, "R9 ready cleared", d, 0);
    t_local(8'h00);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    hb_wr = 0; hb_rd = 0; hb_sel = 0; hb_wdata = 0;
    rm_ack = 0; rm_rdata = 0; rm_err = 0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_read(8'h01, 24'hAB_CDEF, 32'h8765_4321);
    t_read(8'h02, 24'h00_0010, 32'h0000_FFFF);
    t_write(8'h10, 24'h12_0000, 32'hA5A5_0F0F);
    t_write(8'h20, 24'h00_00FF, 32'h1111_2222);
    t_remote_err();
    t_bad_op();
    t_local(8'h00);
    t_local(8'h40);
    t_local(8'h80);
    t_overrun();
    t_drain();
    t_status_wr();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule